// File: doc/BRIEF.md
# Least-Laxity-First Task Dispatcher

This block holds the timing state of a set of active tasks and decides which of them run on a pool of identical processing elements (PEs). Software or a dependency engine loads each task with its real-time flag, its time left to deadline and its worst-case execution time. From then on the block ranks every waiting task against every running task on each clock cycle. Laxity is the time left to the deadline minus the remaining execution time. A real-time task with less laxity ranks higher, and on equal laxity the task with the earlier deadline ranks higher. Non-real-time tasks always rank below real-time ones and are ordered among themselves by remaining execution time, shortest first.

A scheduling tick moves time forward. It lowers the time to deadline of every loaded real-time task and the remaining execution time of every running task. The block issues one command at a time. A command is either a dispatch of a waiting task to an idle PE, or a preemption that replaces the weakest running task with a waiting one. Each command is held until the PE side acknowledges it. A task leaves the block when its PE reports completion.

Top module: `llf_sched`

## Requirements
- R1: After reset there is no pending command, every PE is idle and no deadline-miss flag is set.
- R2: Laxity is the time to deadline minus the remaining execution time, and the waiting real-time task with the smallest laxity is dispatched first.
- R3: On equal laxity the earlier deadline ranks higher. A waiting task that merely equals a running task in both laxity and deadline does not preempt it, and among fully equal waiting tasks the lower task index goes first.
- R4: Each tick lowers the time to deadline of every loaded real-time task by one and the remaining time of every running task by one. A command caused by the new ranking appears on the second rising edge after the tick edge.
- R5: A non-real-time task never preempts. It is dispatched only to an idle PE when no real-time task is waiting, and among non-real-time tasks the shortest remaining time goes first.
- R6: When a PE is idle, the best waiting task is dispatched to the lowest-numbered idle PE (cmd_preempt = 0). No PE ever runs two tasks.
- R7: When every PE is busy, a waiting real-time task that strictly outranks the lowest-ranked running task preempts it (cmd_preempt = 1, cmd_pe = that task's PE). The displaced task returns to waiting. Non-real-time running tasks rank lowest, with the one that has the most remaining time lowest of all.
- R8: A loaded real-time task with negative laxity sets its bit in miss on the next edge. The bit stays set until the task is reloaded or retired.
- R9: Only one command is outstanding. Its fields stay stable until cmd_ack, and cmd_valid is low in the cycle after the acknowledge edge.
- R10: done_valid with done_pe retires the task running on that PE, and the PE reads idle right after that edge.
- R11: A task loaded into an empty block is dispatched with cmd_valid rising on the second edge after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Scheduling time step |
| load_valid | input | 1 | Load a task into slot load_id |
| load_id | input | ID_W | Task slot index |
| load_rt | input | 1 | 1 = real-time task |
| load_deadline | input | DL_W | Time to deadline, signed |
| load_wcet | input | REM_W | Worst-case execution time |
| done_valid | input | 1 | A PE finished its task |
| done_pe | input | PE_W | Index of the finishing PE |
| cmd_valid | output | 1 | Command pending |
| cmd_preempt | output | 1 | 1 = preempt, 0 = dispatch |
| cmd_pe | output | PE_W | Target PE |
| cmd_task | output | ID_W | Task to start on cmd_pe |
| cmd_ack | input | 1 | PE side accepted the command |
| pe_busy | output | NUM_PE | One bit per PE running a task |
| miss | output | NUM_TASKS | Sticky deadline-miss flag per task |

## Verification
Every result has a fixed latency. A load, tick or ack changes registered task state on its own edge, the ranking is combinational in the following cycle, and the command register updates on the next edge. A new command is therefore visible at the second falling edge after its cause. Miss flags follow the same two-edge rule, and pe_busy clears at the first falling edge after a done edge. The bench drives every input at a falling edge and samples exactly at these points. It checks that cmd_valid is still low at the first falling edge, and that no command appears during idle windows where the ranking must hold a task back.

// File: rtl/llf_pkg.sv
package llf_pkg;
  parameter int DL_W  = 16;
  parameter int REM_W = 15;
  parameter int LAX_W = DL_W + 2;

  typedef logic signed [DL_W-1:0]  dl_t;
  typedef logic        [REM_W-1:0] rem_t;
  typedef logic signed [LAX_W-1:0] lax_t;

  typedef struct packed {
    logic rt;
    lax_t lax;
    dl_t  dl;
    rem_t rem;
  } key_t;

  function automatic lax_t laxity(dl_t d, rem_t r);
    lax_t dx;
    lax_t rx;
    dx = {{(LAX_W-DL_W){d[DL_W-1]}}, d};
    rx = {{(LAX_W-REM_W){1'b0}}, r};
    return dx - rx;
  endfunction

  // strict "a ranks above b"
  function automatic logic outranks(key_t a, key_t b);
    if (a.rt != b.rt) return a.rt;
    if (a.rt) begin
      if (a.lax != b.lax) return $signed(a.lax) < $signed(b.lax);
      return $signed(a.dl) < $signed(b.dl);
    end
    return a.rem < b.rem;
  endfunction

  function automatic dl_t dl_step(dl_t d);
    dl_t floor_v;
    floor_v = {1'b1, {(DL_W-1){1'b0}}};
    return (d == floor_v) ? d : d - dl_t'(1);
  endfunction
endpackage

// File: rtl/llf_task_table.sv
module llf_task_table
  import llf_pkg::*;
#(
  parameter int NUM_TASKS = 32,
  parameter int NUM_PE    = 4,
  parameter int ID_W      = 5,
  parameter int PE_W      = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tick,
  input  logic                            load_valid,
  input  logic [ID_W-1:0]                 load_id,
  input  logic                            load_rt,
  input  dl_t                             load_dl,
  input  rem_t                            load_rem,
  input  logic                            done_valid,
  input  logic [PE_W-1:0]                 done_pe,
  input  logic                            apply_valid,
  input  logic                            apply_preempt,
  input  logic [ID_W-1:0]                 apply_task,
  input  logic [PE_W-1:0]                 apply_pe,
  output logic [NUM_TASKS-1:0]            t_valid,
  output logic [NUM_TASKS-1:0]            t_run,
  output logic [NUM_TASKS-1:0][PE_W-1:0]  t_pe,
  output key_t [NUM_TASKS-1:0]            t_key,
  output logic [NUM_TASKS-1:0]            t_miss,
  output logic [NUM_PE-1:0]               pe_busy
);
  logic valid_q [NUM_TASKS];
  logic run_q   [NUM_TASKS];
  logic rt_q    [NUM_TASKS];
  logic miss_q  [NUM_TASKS];
  logic [PE_W-1:0] pe_q [NUM_TASKS];
  dl_t  dl_q    [NUM_TASKS];
  rem_t rem_q   [NUM_TASKS];

  // named events per task, used by logic and assertions
  logic [NUM_TASKS-1:0] load_hit, retire_hit, start_hit, evict_hit, late_now;
  logic [NUM_PE-1:0][NUM_TASKS-1:0] pe_owner;

  for (genvar i = 0; i < NUM_TASKS; i++) begin : g_slot
    lax_t lax_w;
    assign lax_w         = laxity(dl_q[i], rem_q[i]);
    assign load_hit[i]   = load_valid && (load_id == ID_W'(i));
    assign retire_hit[i] = done_valid && run_q[i] && (pe_q[i] == done_pe);
    assign start_hit[i]  = apply_valid && (apply_task == ID_W'(i));
    assign evict_hit[i]  = apply_valid && apply_preempt && run_q[i] &&
                           (pe_q[i] == apply_pe) && !start_hit[i];
    assign late_now[i]   = valid_q[i] && rt_q[i] && lax_w[LAX_W-1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        run_q[i]   <= 1'b0;
        rt_q[i]    <= 1'b0;
        miss_q[i]  <= 1'b0;
        pe_q[i]    <= '0;
        dl_q[i]    <= '0;
        rem_q[i]   <= '0;
      end else if (load_hit[i]) begin
        valid_q[i] <= 1'b1;
        run_q[i]   <= 1'b0;
        rt_q[i]    <= load_rt;
        miss_q[i]  <= 1'b0;
        dl_q[i]    <= load_dl;
        rem_q[i]   <= load_rem;
      end else if (retire_hit[i]) begin
        valid_q[i] <= 1'b0;
        run_q[i]   <= 1'b0;
        miss_q[i]  <= 1'b0;
      end else begin
        if (tick && valid_q[i] && rt_q[i]) dl_q[i] <= dl_step(dl_q[i]);
        if (tick && run_q[i] && rem_q[i] != '0) rem_q[i] <= rem_q[i] - rem_t'(1);
        if (start_hit[i]) begin
          run_q[i] <= 1'b1;
          pe_q[i]  <= apply_pe;
        end else if (evict_hit[i]) begin
          run_q[i] <= 1'b0;
        end
        if (late_now[i]) miss_q[i] <= 1'b1;
      end
    end

    always_comb begin
      t_valid[i]  = valid_q[i];
      t_run[i]    = valid_q[i] && run_q[i];
      t_pe[i]     = pe_q[i];
      t_miss[i]   = miss_q[i];
      t_key[i].rt  = rt_q[i];
      t_key[i].lax = lax_w;
      t_key[i].dl  = dl_q[i];
      t_key[i].rem = rem_q[i];
    end

    AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      miss_q[i] && !load_hit[i] && !retire_hit[i] |=> miss_q[i]); // R8
    AST_MISS_ON_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      late_now[i] && !load_hit[i] && !retire_hit[i] |=> miss_q[i]); // R8
  end

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    always_comb begin
      for (int i = 0; i < NUM_TASKS; i++)
        pe_owner[p][i] = valid_q[i] && run_q[i] && (pe_q[i] == PE_W'(p));
    end
    assign pe_busy[p] = |pe_owner[p];

    AST_ONE_TASK_PER_PE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pe_owner[p]) <= 1); // R6
    AST_DONE_FREES_PE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid && done_pe == PE_W'(p) && !apply_valid |=> !pe_busy[p]); // R10
  end
endmodule

// File: rtl/llf_pick.sv
module llf_pick
  import llf_pkg::*;
#(
  parameter int NUM_TASKS = 32,
  parameter int NUM_PE    = 4,
  parameter int ID_W      = 5,
  parameter int PE_W      = 2
) (
  input  logic [NUM_TASKS-1:0]            t_valid,
  input  logic [NUM_TASKS-1:0]            t_run,
  input  logic [NUM_TASKS-1:0][PE_W-1:0]  t_pe,
  input  key_t [NUM_TASKS-1:0]            t_key,
  input  logic [NUM_PE-1:0]               pe_busy,
  output logic                            go,
  output logic                            go_preempt,
  output logic [PE_W-1:0]                 go_pe,
  output logic [ID_W-1:0]                 go_task
);
  logic            have_wait, have_victim, have_idle, can_preempt;
  logic [ID_W-1:0] best_id;
  key_t            best_key, victim_key;
  logic [PE_W-1:0] victim_pe, idle_pe;

  always_comb begin
    have_wait   = 1'b0;
    best_id     = '0;
    best_key    = '0;
    have_victim = 1'b0;
    victim_key  = '0;
    victim_pe   = '0;
    for (int i = 0; i < NUM_TASKS; i++) begin
      if (t_valid[i] && !t_run[i]) begin
        if (!have_wait || outranks(t_key[i], best_key)) begin
          have_wait = 1'b1;
          best_id   = ID_W'(i);
          best_key  = t_key[i];
        end
      end
      if (t_run[i]) begin
        if (!have_victim || outranks(victim_key, t_key[i])) begin
          have_victim = 1'b1;
          victim_key  = t_key[i];
          victim_pe   = t_pe[i];
        end
      end
    end
    have_idle = 1'b0;
    idle_pe   = '0;
    for (int p = NUM_PE - 1; p >= 0; p--) begin
      if (!pe_busy[p]) begin
        have_idle = 1'b1;
        idle_pe   = PE_W'(p);
      end
    end
  end

  assign can_preempt = have_victim && best_key.rt && outranks(best_key, victim_key);
  assign go          = have_wait && (have_idle || can_preempt);
  assign go_preempt  = !have_idle;
  assign go_pe       = have_idle ? idle_pe : victim_pe;
  assign go_task     = best_id;
endmodule

// File: rtl/llf_cmd.sv
module llf_cmd #(
  parameter int ID_W = 5,
  parameter int PE_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            go_preempt,
  input  logic [PE_W-1:0] go_pe,
  input  logic [ID_W-1:0] go_task,
  input  logic            cmd_ack,
  output logic            cmd_valid,
  output logic            cmd_preempt,
  output logic [PE_W-1:0] cmd_pe,
  output logic [ID_W-1:0] cmd_task,
  output logic            apply_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid   <= 1'b0;
      cmd_preempt <= 1'b0;
      cmd_pe      <= '0;
      cmd_task    <= '0;
    end else if (cmd_valid) begin
      if (cmd_ack) cmd_valid <= 1'b0;
    end else if (go) begin
      cmd_valid   <= 1'b1;
      cmd_preempt <= go_preempt;
      cmd_pe      <= go_pe;
      cmd_task    <= go_task;
    end
  end

  assign apply_valid = cmd_valid && cmd_ack;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_pe) && $stable(cmd_task) && $stable(cmd_preempt)); // R9
  AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ack |=> !cmd_valid); // R9
endmodule

// File: rtl/llf_sched.sv
module llf_sched
  import llf_pkg::*;
#(
  parameter int NUM_TASKS = 32,
  parameter int NUM_PE    = 4,
  parameter int ID_W      = $clog2(NUM_TASKS),
  parameter int PE_W      = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 load_valid,
  input  logic [ID_W-1:0]      load_id,
  input  logic                 load_rt,
  input  logic [DL_W-1:0]      load_deadline,
  input  logic [REM_W-1:0]     load_wcet,
  input  logic                 done_valid,
  input  logic [PE_W-1:0]      done_pe,
  output logic                 cmd_valid,
  output logic                 cmd_preempt,
  output logic [PE_W-1:0]      cmd_pe,
  output logic [ID_W-1:0]      cmd_task,
  input  logic                 cmd_ack,
  output logic [NUM_PE-1:0]    pe_busy,
  output logic [NUM_TASKS-1:0] miss
);
  logic [NUM_TASKS-1:0]           t_valid, t_run;
  logic [NUM_TASKS-1:0][PE_W-1:0] t_pe;
  key_t [NUM_TASKS-1:0]           t_key;
  logic                           go, go_preempt, apply_valid;
  logic [PE_W-1:0]                go_pe;
  logic [ID_W-1:0]                go_task;

  llf_task_table #(.NUM_TASKS(NUM_TASKS), .NUM_PE(NUM_PE), .ID_W(ID_W), .PE_W(PE_W)) u_table (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load_valid(load_valid), .load_id(load_id), .load_rt(load_rt),
    .load_dl(dl_t'(load_deadline)), .load_rem(rem_t'(load_wcet)),
    .done_valid(done_valid), .done_pe(done_pe),
    .apply_valid(apply_valid), .apply_preempt(cmd_preempt),
    .apply_task(cmd_task), .apply_pe(cmd_pe),
    .t_valid(t_valid), .t_run(t_run), .t_pe(t_pe), .t_key(t_key),
    .t_miss(miss), .pe_busy(pe_busy)
  );

  llf_pick #(.NUM_TASKS(NUM_TASKS), .NUM_PE(NUM_PE), .ID_W(ID_W), .PE_W(PE_W)) u_pick (
    .t_valid(t_valid), .t_run(t_run), .t_pe(t_pe), .t_key(t_key), .pe_busy(pe_busy),
    .go(go), .go_preempt(go_preempt), .go_pe(go_pe), .go_task(go_task)
  );

  llf_cmd #(.ID_W(ID_W), .PE_W(PE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .go(go), .go_preempt(go_preempt), .go_pe(go_pe),
    .go_task(go_task), .cmd_ack(cmd_ack), .cmd_valid(cmd_valid),
    .cmd_preempt(cmd_preempt), .cmd_pe(cmd_pe), .cmd_task(cmd_task),
    .apply_valid(apply_valid)
  );

  AST_DISPATCH_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_preempt |-> !pe_busy[cmd_pe]); // R6
  AST_PREEMPT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) && cmd_preempt |-> $past(&pe_busy)); // R7
  AST_PREEMPT_RT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_preempt |-> t_key[cmd_task].rt); // R5
  AST_CMD_TASK_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> t_valid[cmd_task] && !t_run[cmd_task]); // R9
endmodule

// File: tb/llf_sched_test.sv
`timescale 1ns/1ps
module llf_sched_test;
  localparam int NT = 8;
  localparam int NP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        load_valid = 1'b0;
  logic [2:0]  load_id = '0;
  logic        load_rt = 1'b0;
  logic [15:0] load_deadline = '0;
  logic [14:0] load_wcet = '0;
  logic        done_valid = 1'b0;
  logic [0:0]  done_pe = '0;
  logic        cmd_valid, cmd_preempt;
  logic [0:0]  cmd_pe;
  logic [2:0]  cmd_task;
  logic        cmd_ack = 1'b0;
  logic [1:0]  pe_busy;
  logic [7:0]  miss;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  llf_sched #(.NUM_TASKS(NT), .NUM_PE(NP)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_valid(load_valid), .load_id(load_id),
    .load_rt(load_rt), .load_deadline(load_deadline), .load_wcet(load_wcet),
    .done_valid(done_valid), .done_pe(done_pe), .cmd_valid(cmd_valid),
    .cmd_preempt(cmd_preempt), .cmd_pe(cmd_pe), .cmd_task(cmd_task), .cmd_ack(cmd_ack),
    .pe_busy(pe_busy), .miss(miss)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick = 0; load_valid = 0; done_valid = 0; cmd_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(input int id, input bit rt, input int dl, input int w);
    load_id = 3'(id); load_rt = rt; load_deadline = 16'(dl); load_wcet = 15'(w);
    load_valid = 1'b1;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_pe(input int pe);
    done_pe = 1'(pe); done_valid = 1'b1;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic expect_cmd(input bit pre, input int pe, input int id, input string tag);
    int k = 0;
    while (!cmd_valid && k < 12) begin
      @(negedge clk);
      k++;
    end
    chk({tag, " cmd_valid"}, int'(cmd_valid), 1);
    chk({tag, " cmd_preempt"}, int'(cmd_preempt), int'(pre));
    chk({tag, " cmd_pe"}, int'(cmd_pe), pe);
    chk({tag, " cmd_task"}, int'(cmd_task), id);
    cmd_ack = 1'b1;
    @(negedge clk);
    cmd_ack = 1'b0;
    chk("R9 no command right after ack", int'(cmd_valid), 0);
  endtask

  task automatic expect_idle(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      chk(tag, int'(cmd_valid), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 cmd_valid", int'(cmd_valid), 0);
    chk("R1 pe_busy", int'(pe_busy), 0);
    chk("R1 miss", int'(miss), 0);
  endtask

  task automatic t_llf_order();
    do_reset();
    load(0, 1, 50, 49);                 // laxity 1
    chk("R11 first edge no cmd", int'(cmd_valid), 0);
    @(negedge clk);
    chk("R11 second edge cmd", int'(cmd_valid), 1);
    expect_cmd(0, 0, 0, "R11 R6 dispatch pe0");
    load(1, 1, 50, 48);                 // laxity 2
    expect_cmd(0, 1, 1, "R6 next idle pe1");
    chk("R6 both busy", int'(pe_busy), 3);
    load(4, 1, 20, 5);                  // laxity 15
    load(5, 1, 12, 8);                  // laxity 4
    load(6, 1, 30, 2);                  // laxity 28
    expect_idle(4, "R2 no preempt of tighter tasks");
    finish_pe(0);
    chk("R10 pe0 idle after done", int'(pe_busy), 2);
    expect_cmd(0, 0, 5, "R2 least laxity first");
    finish_pe(1);
    expect_cmd(0, 1, 4, "R2 second least laxity");
    finish_pe(0);
    expect_cmd(0, 0, 6, "R2 last");
  endtask

  task automatic t_tie();
    do_reset();
    load(0, 1, 20, 10);                 // laxity 10
    expect_cmd(0, 0, 0, "R6 setup");
    load(1, 1, 50, 49);                 // laxity 1
    expect_cmd(0, 1, 1, "R6 setup");
    load(2, 1, 20, 10);                 // identical to task 0
    expect_idle(5, "R3 equal task held back");
    load(3, 1, 18, 8);                  // laxity 10, earlier deadline
    expect_cmd(1, 0, 3, "R3 R7 earlier deadline preempts");
    expect_idle(4, "R3 no swap back");
    finish_pe(0);
    expect_cmd(0, 0, 0, "R3 lower index on full tie");
  endtask

  task automatic t_tick();
    do_reset();
    load(0, 1, 10, 4);                  // laxity 6
    expect_cmd(0, 0, 0, "R4 setup");
    load(1, 1, 50, 43);                 // laxity 7
    expect_cmd(0, 1, 1, "R4 setup");
    load(2, 1, 20, 11);                 // laxity 9 waiting
    expect_idle(3, "R4 before ticks");
    do_tick();
    expect_idle(3, "R4 one tick laxity 8");
    do_tick();
    chk("R4 first edge after tick", int'(cmd_valid), 0);
    @(negedge clk);
    chk("R4 second edge after tick", int'(cmd_valid), 1);
    expect_cmd(1, 1, 2, "R4 R7 overtakes running laxity");
  endtask

  task automatic t_nonrt();
    do_reset();
    load(0, 0, 0, 50);
    expect_cmd(0, 0, 0, "R5 nrt to idle pe");
    load(1, 0, 0, 60);
    expect_cmd(0, 1, 1, "R5 nrt to idle pe");
    load(2, 0, 0, 5);
    expect_idle(4, "R5 nrt never preempts");
    load(3, 1, 40, 10);
    expect_cmd(1, 1, 3, "R7 rt preempts longest nrt");
    finish_pe(0);
    expect_cmd(0, 0, 2, "R5 shortest nrt first");
    finish_pe(0);
    expect_cmd(0, 0, 1, "R7 displaced task resumes");
  endtask

  task automatic t_miss();
    do_reset();
    load(0, 1, 5, 5);                   // laxity 0
    expect_cmd(0, 0, 0, "R8 setup");
    load(1, 1, 5, 5);
    expect_cmd(0, 1, 1, "R8 setup");
    load(2, 1, 12, 10);                 // laxity 2 waiting
    do_tick();
    @(negedge clk);
    chk("R8 laxity 1 no miss", int'(miss), 0);
    do_tick();
    @(negedge clk);
    chk("R8 laxity 0 no miss", int'(miss), 0);
    do_tick();
    chk("R8 miss not before second edge", int'(miss[2]), 0);
    @(negedge clk);
    chk("R8 miss on negative laxity", int'(miss[2]), 1);
    expect_cmd(1, 0, 2, "R7 tie victim lower index");
    expect_idle(3, "R3 equal laxity and deadline held");
    chk("R8 miss sticky", int'(miss[2]), 1);
    chk("R8 running zero laxity no miss", int'(miss[1]), 0);
    finish_pe(0);
    chk("R8 miss cleared on retire", int'(miss[2]), 0);
    expect_cmd(0, 0, 0, "R10 freed pe reused");
    load(3, 1, 2, 5);
    chk("R8 load miss first edge", int'(miss[3]), 0);
    @(negedge clk);
    chk("R8 load miss second edge", int'(miss[3]), 1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      summary();
    end
  end

  initial begin
    t_reset_state();
    t_llf_order();
    t_tie();
    t_tick();
    t_nonrt();
    t_miss();
    summary();
  end
endmodule